// File: doc/BRIEF.md
# Source-Routed Register Transaction Hop

This block is one stage in a chain of register-access routers. A request arrives with a 32-bit register address, write data and a read/write flag. The upper 18 address bits hold a route made of six 3-bit hop fields, and the lower 14 bits hold the register index inside the destination module. The block reads the leading hop field (address bits [31:29]). It removes that field by shifting the route left by three bits, with zeros entering at the bottom. It then forwards the request on the output port that the field named. Each later router therefore finds its own field at the top of the address, and the index travels through the chain unchanged.

Port 0 is the router's own small register file. Ports 1 to 7 lead to modules or to further routers. A parameter mask marks which of ports 1 to 7 are wired. A request aimed at an unwired port gets an error response and is not forwarded. Responses come back on the reverse path through the router. Every channel uses a valid/ready handshake, and a router holds only one transaction at a time.

Top module: `hreg_router`

## Requirements
- R1: The output port is taken from address bits [31:29]. For a forwarded request, exactly the `dn_req_valid` bit of that port goes high, and it stays high with stable payload until that port's `dn_req_ready` is seen.
- R2: The forwarded address is {addr[28:14], 3'b000, addr[13:0]}. The route moves up by one field, zeros fill the lowest field, and the 14-bit index is unchanged.
- R3: Field value 0 selects the local register file and never raises any `dn_req_valid`. A local write (`req_write`=1) to an index below LREGS stores the data and responds with data 0 and `rsp_err`=0. A local read returns the stored word with `rsp_err`=0.
- R4: A local index at or above LREGS is not implemented. A write to it is discarded with an OK response and changes no implemented register, including the one whose low index bits match. A read of it returns all zeros with `rsp_err`=0.
- R5: A field value whose bit in PORT_MASK is 0 (port 7 by default) produces `rsp_err`=1 with data 0, and no `dn_req_valid` bit rises.
- R6: A forwarded transaction's upstream response carries the selected port's `dn_rsp_rdata` slice and `dn_rsp_err` bit unchanged.
- R7: After a request is accepted, `req_ready` stays low until its response has been taken with `rsp_valid` and `rsp_ready` both high.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_rdata` and `rsp_err` hold their values.
- R9: Right after reset, `req_ready` is 1, `rsp_valid` is 0 and all `dn_req_valid` bits are 0.
- R10: Route 2.3.0.0.0.0 (address 0x4C00_0123) leaves on port 2 as 0x6000_0123. Route 2.4.2.7.0.0 (address 0x5170_0123) leaves on port 2 as 0x8B80_0123.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Upstream request valid |
| req_ready | output | 1 | Router can accept a request |
| req_addr | input | 32 | Route field [31:14] and register index [13:0] |
| req_wdata | input | DW | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Upstream response valid |
| rsp_ready | input | 1 | Upstream takes the response |
| rsp_rdata | output | DW | Response data |
| rsp_err | output | 1 | Error response flag |
| dn_req_valid | output | 8 | Per-port forwarded request valid (bit 0 unused) |
| dn_req_ready | input | 8 | Per-port request ready |
| dn_req_addr | output | 32 | Shifted address, shared by all ports |
| dn_req_wdata | output | DW | Forwarded write data |
| dn_req_write | output | 1 | Forwarded read/write flag |
| dn_rsp_valid | input | 8 | Per-port response valid |
| dn_rsp_ready | output | 8 | Per-port response ready |
| dn_rsp_rdata | input | 8*DW | Per-port response data, port p at [p*DW +: DW] |
| dn_rsp_err | input | 8 | Per-port response error |

## Verification
Two things can meet in the same cycle: a finished response that is held by upstream back-pressure, and the next request already waiting at the input. The bench provokes this by holding `rsp_ready` low for several cycles on a delayed forwarded response while the driver already holds `req_valid` high with a new address. In each stalled cycle it checks that `req_ready` stays low and that the pending response data and error flag have not moved. After that it checks that the queued request goes out with its own shifted address and that its response comes back in order.

// File: rtl/hrr_pkg.sv
package hrr_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_FWD  = 2'd1,
    S_WAIT = 2'd2,
    S_RESP = 2'd3
  } hop_state_t;
endpackage

// File: rtl/hrr_path_decode.sv
module hrr_path_decode #(
  parameter int FIELD_W = 3,
  parameter int PATH_W  = 18,
  parameter int IDX_W   = 14
) (
  input  logic [PATH_W+IDX_W-1:0] addr_in,
  output logic [FIELD_W-1:0]      hop_port,
  output logic [PATH_W+IDX_W-1:0] addr_next
);
  localparam int AW = PATH_W + IDX_W;

  // leading hop field chooses the port; remaining route moves up one field
  assign hop_port  = addr_in[AW-1 -: FIELD_W];
  assign addr_next = {addr_in[AW-FIELD_W-1:IDX_W], {FIELD_W{1'b0}}, addr_in[IDX_W-1:0]};
endmodule

// File: rtl/hrr_local_regs.sv
module hrr_local_regs #(
  parameter int DW    = 32,
  parameter int IDX_W = 14,
  parameter int LREGS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  localparam int LA = (LREGS > 1) ? $clog2(LREGS) : 1;

  logic [DW-1:0] mem [LREGS];
  logic [DW-1:0] rd_q;
  logic          hit_q;
  logic          hit;

  assign hit = (idx < IDX_W'(LREGS));

  // plain synchronous array so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (en && we && hit) mem[idx[LA-1:0]] <= wdata;
    if (en) rd_q <= mem[idx[LA-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst)     hit_q <= 1'b0;
    else if (en) hit_q <= hit && !we;
  end

  // writes and unimplemented indices answer with zeros
  assign rdata = hit_q ? rd_q : '0;
endmodule

// File: rtl/hreg_router.sv
module hreg_router
  import hrr_pkg::*;
#(
  parameter int DW      = 32,
  parameter int FIELD_W = 3,
  parameter int PATH_W  = 18,
  parameter int IDX_W   = 14,
  parameter int LREGS   = 8,
  parameter logic [(1<<FIELD_W)-1:0] PORT_MASK = 8'h7F
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             req_valid,
  output logic                             req_ready,
  input  logic [PATH_W+IDX_W-1:0]          req_addr,
  input  logic [DW-1:0]                    req_wdata,
  input  logic                             req_write,
  output logic                             rsp_valid,
  input  logic                             rsp_ready,
  output logic [DW-1:0]                    rsp_rdata,
  output logic                             rsp_err,
  output logic [(1<<FIELD_W)-1:0]          dn_req_valid,
  input  logic [(1<<FIELD_W)-1:0]          dn_req_ready,
  output logic [PATH_W+IDX_W-1:0]          dn_req_addr,
  output logic [DW-1:0]                    dn_req_wdata,
  output logic                             dn_req_write,
  input  logic [(1<<FIELD_W)-1:0]          dn_rsp_valid,
  output logic [(1<<FIELD_W)-1:0]          dn_rsp_ready,
  input  logic [(1<<FIELD_W)*DW-1:0]       dn_rsp_rdata,
  input  logic [(1<<FIELD_W)-1:0]          dn_rsp_err
);
  localparam int NPORT = 1 << FIELD_W;
  localparam int AW    = PATH_W + IDX_W;

  hop_state_t         state;
  logic [FIELD_W-1:0] hop_port;
  logic [AW-1:0]      addr_next;
  logic [FIELD_W-1:0] sel_q;
  logic               loc_q;
  logic [DW-1:0]      rsp_rdata_q;
  logic               rsp_err_q;
  logic [NPORT-1:0]   dn_valid_q;
  logic [DW-1:0]      loc_rdata;
  logic               accept;
  logic               loc_en;

  hrr_path_decode #(.FIELD_W(FIELD_W), .PATH_W(PATH_W), .IDX_W(IDX_W)) u_dec (
    .addr_in  (req_addr),
    .hop_port (hop_port),
    .addr_next(addr_next)
  );

  assign req_ready = (state == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign loc_en    = accept && (hop_port == '0);

  hrr_local_regs #(.DW(DW), .IDX_W(IDX_W), .LREGS(LREGS)) u_regs (
    .clk  (clk),
    .rst  (rst),
    .en   (loc_en),
    .we   (req_write),
    .idx  (req_addr[IDX_W-1:0]),
    .wdata(req_wdata),
    .rdata(loc_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      sel_q        <= '0;
      loc_q        <= 1'b0;
      rsp_rdata_q  <= '0;
      rsp_err_q    <= 1'b0;
      dn_valid_q   <= '0;
      dn_req_addr  <= '0;
      dn_req_wdata <= '0;
      dn_req_write <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          dn_req_addr  <= addr_next;
          dn_req_wdata <= req_wdata;
          dn_req_write <= req_write;
          sel_q        <= hop_port;
          if (hop_port == '0) begin
            loc_q <= 1'b1;
            state <= S_RESP;
          end else if (!PORT_MASK[hop_port]) begin
            loc_q       <= 1'b0;
            rsp_rdata_q <= '0;
            rsp_err_q   <= 1'b1;
            state       <= S_RESP;
          end else begin
            loc_q      <= 1'b0;
            dn_valid_q <= NPORT'(1) << hop_port;
            state      <= S_FWD;
          end
        end
        S_FWD: if (dn_req_ready[sel_q]) begin
          dn_valid_q <= '0;
          state      <= S_WAIT;
        end
        S_WAIT: if (dn_rsp_valid[sel_q]) begin
          rsp_rdata_q <= dn_rsp_rdata[sel_q*DW +: DW];
          rsp_err_q   <= dn_rsp_err[sel_q];
          state       <= S_RESP;
        end
        S_RESP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign dn_req_valid = dn_valid_q;
  assign dn_rsp_ready = (state == S_WAIT) ? (NPORT'(1) << sel_q) : '0;
  assign rsp_valid    = (state == S_RESP);
  assign rsp_rdata    = loc_q ? loc_rdata : rsp_rdata_q;
  assign rsp_err      = loc_q ? 1'b0 : rsp_err_q;

  // R1: at most one port carries a forwarded request
  p_dn_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dn_req_valid));

  // R1: a stalled forwarded request keeps its port and payload
  p_dn_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (|(dn_req_valid & ~dn_req_ready)) |=>
      (dn_req_valid == $past(dn_req_valid)) && $stable(dn_req_addr) && $stable(dn_req_wdata));

  // R2: the lowest route field is zero-filled on every forwarded address
  p_zero_fill_r2: assert property (@(posedge clk) disable iff (rst)
    (|dn_req_valid) |-> (dn_req_addr[FIELD_W+IDX_W-1:IDX_W] == '0));

  // R3: the local port is never driven outward
  p_no_self_fwd_r3: assert property (@(posedge clk) disable iff (rst)
    !dn_req_valid[0]);

  // R5: unwired ports never see a request
  p_unwired_r5: assert property (@(posedge clk) disable iff (rst)
    (dn_req_valid & ~PORT_MASK) == '0);

  // R7: an accepted request closes the input on the next cycle
  p_single_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R8: a back-pressured response holds still
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));
endmodule

// File: tb/sim_hreg_router.sv
module sim_hreg_router;
  localparam int DW = 32;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           req_valid = 1'b0;
  logic           req_ready;
  logic [31:0]    req_addr = '0;
  logic [DW-1:0]  req_wdata = '0;
  logic           req_write = 1'b0;
  logic           rsp_valid;
  logic           rsp_ready;
  logic [DW-1:0]  rsp_rdata;
  logic           rsp_err;
  logic [7:0]     dn_req_valid;
  logic [7:0]     dn_req_ready;
  logic [31:0]    dn_req_addr;
  logic [DW-1:0]  dn_req_wdata;
  logic           dn_req_write;
  logic [7:0]     dn_rsp_valid;
  logic [7:0]     dn_rsp_ready;
  logic [8*DW-1:0] dn_rsp_rdata;
  logic [7:0]     dn_rsp_err;

  always #5 clk = ~clk;

  hreg_router u0 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready), .dn_req_addr(dn_req_addr),
    .dn_req_wdata(dn_req_wdata), .dn_req_write(dn_req_write),
    .dn_rsp_valid(dn_rsp_valid), .dn_rsp_ready(dn_rsp_ready),
    .dn_rsp_rdata(dn_rsp_rdata), .dn_rsp_err(dn_rsp_err)
  );

  typedef struct {
    logic [DW-1:0] rdata;
    logic          err;
    int            stall;
    string         tag;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0;
  int          n_fail = 0;
  int          fwd_seen = 0;
  int          fwd_expect = 0;
  int          exp_port = 0;
  logic [31:0] exp_fwd = '0;
  int          cur_lat = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] shifted(input logic [31:0] a);
    return {a[28:14], 3'b000, a[13:0]};
  endfunction

  function automatic logic [31:0] dn_data(input logic [31:0] fa, input int p);
    return fa ^ 32'h5A5A_0000 ^ 32'(p);
  endfunction

  // driver: pushes the expected response, then offers the request
  task automatic send(input logic [31:0] a, input logic wr, input logic [DW-1:0] wd,
                      input logic [DW-1:0] erd, input logic eerr, input int port,
                      input int lat, input int stall, input string tag);
    exp_t e;
    e.rdata = erd; e.err = eerr; e.stall = stall; e.tag = tag;
    @(negedge clk);
    req_addr = a; req_write = wr; req_wdata = wd; req_valid = 1'b1;
    forever begin
      if (req_ready) begin
        sb.push_back(e);
        @(posedge clk);
        exp_port = port; exp_fwd = shifted(a); cur_lat = lat;
        if (port != 0) fwd_expect++;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic loc_wr(input int idx, input logic [DW-1:0] d, input string tag);
    send(32'(idx), 1'b1, d, '0, 1'b0, 0, 0, 0, tag);
  endtask

  task automatic loc_rd(input int idx, input logic [DW-1:0] e, input string tag);
    send(32'(idx), 1'b0, '0, e, 1'b0, 0, 0, 0, tag);
  endtask

  task automatic fwd(input logic [31:0] a, input logic wr, input int lat, input int stall,
                     input string tag);
    int p;
    p = int'(a[31:29]);
    if (p == 7) send(a, wr, 32'h1234_5678, '0, 1'b1, 0, lat, stall, tag);
    else send(a, wr, 32'h1234_5678, dn_data(shifted(a), p), (a[3:0] == 4'hE), p, lat, stall, tag);
  endtask

  task automatic drain(input string req);
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(fwd_seen == fwd_expect, req, "forward count", 32'(fwd_seen), 32'(fwd_expect));
  endtask

  // downstream model for ports 1..7
  initial begin
    int p;
    logic [31:0] fa;
    dn_req_ready = '0; dn_rsp_valid = '0; dn_rsp_rdata = '0; dn_rsp_err = '0;
    forever begin
      @(negedge clk);
      if (|dn_req_valid) begin
        p = 0;
        for (int i = 0; i < 8; i++) if (dn_req_valid[i]) p = i;
        fwd_seen++;
        fa = dn_req_addr;
        chk(p == exp_port, "R1", "forward port", 32'(p), 32'(exp_port));
        chk(fa == exp_fwd, "R2", "forward address", fa, exp_fwd);
        dn_req_ready[p] = 1'b1;
        @(negedge clk);
        dn_req_ready[p] = 1'b0;
        repeat (cur_lat) @(negedge clk);
        dn_rsp_valid[p] = 1'b1;
        dn_rsp_rdata[p*DW +: DW] = dn_data(fa, p);
        dn_rsp_err[p] = (fa[3:0] == 4'hE);
        @(negedge clk);
        dn_rsp_valid[p] = 1'b0;
      end
    end
  end

  // monitor: compares responses in order, applies back-pressure
  initial begin
    rsp_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (rsp_valid && !rst) begin
        chk(req_ready == 1'b0, "R7", "ready while response pending", 32'(req_ready), 32'd0);
        if (sb.size() == 0) begin
          chk(1'b0, "R6", "unexpected response", rsp_rdata, '0);
          rsp_ready = 1'b1;
        end else if (sb[0].stall > 0) begin
          sb[0].stall--;
          rsp_ready = 1'b0;
          chk(rsp_rdata == sb[0].rdata, "R8", {"held data ", sb[0].tag}, rsp_rdata, sb[0].rdata);
        end else begin
          chk(rsp_rdata == sb[0].rdata, sb[0].tag, "response data", rsp_rdata, sb[0].rdata);
          chk(rsp_err == sb[0].err, sb[0].tag, "response error", 32'(rsp_err), 32'(sb[0].err));
          void'(sb.pop_front());
          rsp_ready = 1'b1;
        end
      end else begin
        rsp_ready = 1'b0;
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: idle state after reset
    chk(req_ready == 1'b1, "R9", "req_ready", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R9", "rsp_valid", 32'(rsp_valid), 32'd0);
    chk(dn_req_valid == '0, "R9", "dn_req_valid", 32'(dn_req_valid), 32'd0);

    // R3: local register file
    loc_wr(1, 32'hDEAD_BEEF, "R3");
    loc_wr(5, 32'h0BAD_F00D, "R3");
    loc_rd(1, 32'hDEAD_BEEF, "R3");
    loc_rd(5, 32'h0BAD_F00D, "R3");
    // R4: index 9 aliases index 1 in its low bits but is unimplemented
    loc_wr(9, 32'h1111_2222, "R4");
    loc_rd(9, 32'h0, "R4");
    loc_rd(1, 32'hDEAD_BEEF, "R4");
    loc_rd(16'h3FFF, 32'h0, "R4");
    drain("R3");

    // R10: example routes
    fwd(32'h4C00_0123, 1'b0, 0, 0, "R10");
    fwd(32'h5170_0123, 1'b1, 1, 0, "R10");
    chk(shifted(32'h5170_0123) == 32'h8B80_0123, "R10", "route encoding", shifted(32'h5170_0123), 32'h8B80_0123);
    drain("R10");

    // R1/R2: each wired port with a distinct path
    for (int p = 1; p < 7; p++)
      fwd((32'(p) << 29) | (32'(7 - p) << 26) | (32'(p) << 20) | 32'(p * 3), 1'b0, p % 3, 0, "R1");
    drain("R1");

    // R5: unwired port 7
    fwd(32'hE000_0010, 1'b0, 0, 0, "R5");
    fwd(32'hFFFF_FFFE, 1'b1, 0, 2, "R5");
    drain("R5");

    // R6/R7/R8: delayed response with error, held by back-pressure
    // while the next request is already waiting
    fwd(32'hA5C0_3FFE, 1'b0, 3, 4, "R6");
    fwd(32'h2A00_100E, 1'b1, 0, 3, "R7");
    fwd(32'h6000_0001, 1'b0, 2, 0, "R8");
    loc_rd(5, 32'h0BAD_F00D, "R7");
    drain("R6");

    finish_run();
  end
endmodule